// File: doc/BRIEF.md
# Multi-Agent Bandwidth Arbiter

This block decides which of several requesting agents may issue commands to a shared DRAM controller. Each agent raises a request line. The block returns a registered one-hot grant. The granted agent keeps the grant until its request falls, until it has issued a guaranteed number of commands while another agent is waiting, or until it reaches a per-agent command cap. Each command the controller takes from the holder is signalled by a one-cycle `cmd_accept` pulse.

Each agent has three settings: a burst cap (`lim`), a guaranteed command count (`cmd`) and a starvation period (`prd`). Software loads them through an indirect pair of writes. The first write stores a select value equal to the agent index times the width of the target field. The second write carries the value and names the field. A waiting agent counts time in ticks of four clocks. When its period runs out it becomes urgent, and urgent agents win the next arbitration ahead of all others. Among equal candidates, round-robin order starts just after the last agent granted.

There is no data path. Software writes are plain strobes and take effect on the clock edge where they are sampled. The command stream itself is handshaked downstream, and this block only counts the resulting accept pulses. No back-pressure is applied at this block's edge.

Top module: `bw_arbiter`

## Requirements
- R1: After reset the grant is zero. The defaults are: `lim` = 31, 31, 31, 4, 4; `cmd` = 4, 16, 16, 4, 4; `prd` = 255 (agents 0 to 4). The round-robin pointer starts so that agent 0 is first in line.
- R2: `grant` is always zero or one-hot.
- R3: While a holder exists and none of the release conditions of R4, R5 and R6 is met, `grant` does not change.
- R4: The holder releases on the edge where its accepted count (including that cycle's `cmd_accept`) is at least its `cmd` value while another agent requests.
- R5: The holder releases on the edge where its own request is low. The new grant then goes to a different requester, or to zero.
- R6: The holder releases on the edge where its accepted count reaches its `lim` value, even if it is alone. On any release edge the releasing agent cannot win, so a lone requester sees one cycle of zero grant.
- R7: When the grant is free or released, the winner is the first eligible requester in the cyclic order that starts after the last granted agent. `cmd_accept` is ignored while the grant is zero.
- R8: A requester that is not granted counts ticks. On a tick where its count equals `prd` it becomes urgent. Urgent eligible agents take precedence over non-urgent ones, with round-robin among them. Urgency and the count clear when the agent is granted or drops its request.
- R9: A select write stores `sel_wdata`. A field write updates agent i only if the stored select equals i*5 for `lim`, i*8 for `prd` or i*5 for `cmd`, with i below the agent count. Any other select value leaves every setting unchanged. A field write uses the select value stored before that edge. A field write takes the low field bits of `wdata`.
- R10: A tick occurs on every fourth clock edge after reset, starting with the fourth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_we | input | 1 | Write strobe for the select register |
| sel_wdata | input | 8 | Select value: agent index times field width |
| lim_we | input | 1 | Write strobe for the burst cap field |
| prd_we | input | 1 | Write strobe for the period field |
| cmd_we | input | 1 | Write strobe for the guaranteed count field |
| wdata | input | 8 | Field value |
| req | input | 5 | Request, one bit per agent |
| cmd_accept | input | 1 | One pulse per command taken from the holder |
| grant | output | 5 | Registered one-hot grant, or zero |

## Verification
A wrong command count or a wrong setting shows on `grant` only at the holder's release edge. That edge comes early or late by the size of the error, so the bench keeps several agents busy with accept pulses. A wrong tick or wrong urgency state stays hidden until the next arbitration. At that point an urgent agent wins out of its round-robin turn. Short periods and a long random run make that point arrive within a few dozen cycles. A decoding error in the select scheme appears the first time the affected agent releases under its new setting.

// File: rtl/bwa_pkg.sv
`timescale 1ns/1ps
package bwa_pkg;

  // Burst cap default per agent index
  function automatic int dflt_lim(input int idx);
    return (idx < 3) ? 31 : 4;
  endfunction

  // Guaranteed command count default per agent index
  function automatic int dflt_cmd(input int idx);
    return (idx == 1 || idx == 2) ? 16 : 4;
  endfunction

  // Starvation period default, in ticks
  function automatic int dflt_prd(input int idx);
    return (idx >= 0) ? 255 : 0;
  endfunction

endpackage

// File: rtl/bwa_cfg_regs.sv
`timescale 1ns/1ps
module bwa_cfg_regs #(
  parameter int N      = 5,
  parameter int SEL_W  = 8,
  parameter int DATA_W = 8,
  parameter int LIM_W  = 5,
  parameter int PRD_W  = 8,
  parameter int CMD_W  = 5
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      sel_we,
  input  logic [SEL_W-1:0]          sel_wdata,
  input  logic                      lim_we,
  input  logic                      prd_we,
  input  logic                      cmd_we,
  input  logic [DATA_W-1:0]         wdata,
  output logic [N-1:0][LIM_W-1:0]   lim,
  output logic [N-1:0][PRD_W-1:0]   prd,
  output logic [N-1:0][CMD_W-1:0]   cmd
);

  logic [SEL_W-1:0] sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sel_q <= '0;
    else if (sel_we) sel_q <= sel_wdata;
  end

  for (genvar i = 0; i < N; i++) begin : g_agent
    localparam logic [SEL_W-1:0] LIM_KEY = SEL_W'(i * LIM_W);
    localparam logic [SEL_W-1:0] PRD_KEY = SEL_W'(i * PRD_W);
    localparam logic [SEL_W-1:0] CMD_KEY = SEL_W'(i * CMD_W);

    logic [LIM_W-1:0] lim_r;
    logic [PRD_W-1:0] prd_r;
    logic [CMD_W-1:0] cmd_r;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lim_r <= LIM_W'(bwa_pkg::dflt_lim(i));
        prd_r <= PRD_W'(bwa_pkg::dflt_prd(i));
        cmd_r <= CMD_W'(bwa_pkg::dflt_cmd(i));
      end else begin
        if (lim_we && sel_q == LIM_KEY) lim_r <= wdata[LIM_W-1:0];
        if (prd_we && sel_q == PRD_KEY) prd_r <= wdata[PRD_W-1:0];
        if (cmd_we && sel_q == CMD_KEY) cmd_r <= wdata[CMD_W-1:0];
      end
    end

    assign lim[i] = lim_r;
    assign prd[i] = prd_r;
    assign cmd[i] = cmd_r;
  end

endmodule

// File: rtl/bwa_age.sv
`timescale 1ns/1ps
module bwa_age #(
  parameter int PRD_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             waiting,
  input  logic [PRD_W-1:0] period,
  output logic             urgent
);

  logic [PRD_W-1:0] wait_q;
  logic             urg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_q <= '0;
      urg_q  <= 1'b0;
    end else if (!waiting) begin
      wait_q <= '0;
      urg_q  <= 1'b0;
    end else if (tick && !urg_q) begin
      if (wait_q == period) urg_q  <= 1'b1;
      else                  wait_q <= wait_q + 1'b1;
    end
  end

  assign urgent = urg_q;

endmodule

// File: rtl/bwa_rr_pick.sv
`timescale 1ns/1ps
module bwa_rr_pick #(
  parameter int N     = 5,
  parameter int IDX_W = 3
) (
  input  logic [N-1:0]     cand,
  input  logic [IDX_W-1:0] last,
  output logic             found,
  output logic [IDX_W-1:0] win
);

  always_comb begin
    found = 1'b0;
    win   = last;
    for (int k = 1; k <= N; k++) begin
      logic [IDX_W:0] pos;
      pos = {1'b0, last} + (IDX_W+1)'(k);
      if (pos >= (IDX_W+1)'(N)) pos = pos - (IDX_W+1)'(N);
      if (!found && cand[pos[IDX_W-1:0]]) begin
        found = 1'b1;
        win   = pos[IDX_W-1:0];
      end
    end
  end

endmodule

// File: rtl/bw_arbiter.sv
`timescale 1ns/1ps
module bw_arbiter #(
  parameter int N_AGENTS = 5,
  parameter int SEL_W    = 8,
  parameter int DATA_W   = 8,
  parameter int LIM_W    = 5,
  parameter int PRD_W    = 8,
  parameter int CMD_W    = 5,
  parameter int PRESCALE = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sel_we,
  input  logic [SEL_W-1:0]    sel_wdata,
  input  logic                lim_we,
  input  logic                prd_we,
  input  logic                cmd_we,
  input  logic [DATA_W-1:0]   wdata,
  input  logic [N_AGENTS-1:0] req,
  input  logic                cmd_accept,
  output logic [N_AGENTS-1:0] grant
);

  localparam int IDX_W = (N_AGENTS > 1) ? $clog2(N_AGENTS) : 1;
  localparam int PS_W  = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam int CNT_W = ((LIM_W > CMD_W) ? LIM_W : CMD_W) + 1;

  logic [N_AGENTS-1:0][LIM_W-1:0] lim_v;
  logic [N_AGENTS-1:0][PRD_W-1:0] prd_v;
  logic [N_AGENTS-1:0][CMD_W-1:0] cmd_v;

  bwa_cfg_regs #(
    .N(N_AGENTS), .SEL_W(SEL_W), .DATA_W(DATA_W),
    .LIM_W(LIM_W), .PRD_W(PRD_W), .CMD_W(CMD_W)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n),
    .sel_we(sel_we), .sel_wdata(sel_wdata),
    .lim_we(lim_we), .prd_we(prd_we), .cmd_we(cmd_we), .wdata(wdata),
    .lim(lim_v), .prd(prd_v), .cmd(cmd_v)
  );

  // Shared tick prescaler
  logic [PS_W-1:0] pres_q;
  logic            tick;

  assign tick = (pres_q == PS_W'(PRESCALE - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pres_q <= '0;
    else if (tick) pres_q <= '0;
    else           pres_q <= pres_q + 1'b1;
  end

  // Grant state
  logic [N_AGENTS-1:0] grant_q;
  logic [IDX_W-1:0]    hold_q;
  logic [IDX_W-1:0]    last_q;
  logic [CNT_W-1:0]    cnt_q;

  // Per-agent starvation timers
  logic [N_AGENTS-1:0] urg;

  for (genvar i = 0; i < N_AGENTS; i++) begin : g_age
    bwa_age #(.PRD_W(PRD_W)) u_age (
      .clk(clk), .rst_n(rst_n), .tick(tick),
      .waiting(req[i] && !grant_q[i]),
      .period(prd_v[i]),
      .urgent(urg[i])
    );
  end

  // Release decision for the current holder
  logic             busy;
  logic             others;
  logic [CNT_W-1:0] cnt_n;
  logic             rel;

  assign busy   = |grant_q;
  assign others = |(req & ~grant_q);
  assign cnt_n  = cnt_q + CNT_W'(cmd_accept);

  always_comb begin
    rel = 1'b0;
    if (busy) begin
      if (!req[hold_q])                                    rel = 1'b1;
      else if (cnt_n >= CNT_W'(cmd_v[hold_q]) && others)   rel = 1'b1;
      else if (cnt_n >= CNT_W'(lim_v[hold_q]))             rel = 1'b1;
    end
  end

  // Candidate selection: urgent agents first, then all eligible
  logic [N_AGENTS-1:0] elig;
  logic [N_AGENTS-1:0] cand;
  logic                found;
  logic [IDX_W-1:0]    win;

  always_comb begin
    if (!busy)    elig = req;
    else if (rel) elig = req & ~grant_q;
    else          elig = '0;
    cand = (|(elig & urg)) ? (elig & urg) : elig;
  end

  bwa_rr_pick #(.N(N_AGENTS), .IDX_W(IDX_W)) u_pick (
    .cand(cand), .last(last_q), .found(found), .win(win)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant_q <= '0;
      hold_q  <= '0;
      last_q  <= IDX_W'(N_AGENTS - 1);
      cnt_q   <= '0;
    end else if (!busy || rel) begin
      cnt_q <= '0;
      if (found) begin
        grant_q <= N_AGENTS'(1) << win;
        hold_q  <= win;
        last_q  <= win;
      end else begin
        grant_q <= '0;
      end
    end else begin
      cnt_q <= cnt_n;
    end
  end

  assign grant = grant_q;

endmodule

// File: rtl/bw_arbiter_chk.sv
`timescale 1ns/1ps
module bw_arbiter_chk #(
  parameter int N = 5
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] req,
  input logic [N-1:0] grant,
  input logic         rel,
  input logic [N-1:0] urg
);

  AST_GNT_ONEHOT0: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant)); // R2

  AST_GNT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (|grant) && !rel |=> grant == $past(grant)); // R3

  AST_DROP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (|(grant & ~req)) |=> (grant & $past(grant)) == '0); // R5

  AST_NEW_GNT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (grant != $past(grant)) && (|grant) |-> (|(grant & $past(req)))); // R7

  AST_URG_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (|grant) |=> (urg & $past(grant)) == '0); // R8

endmodule

bind bw_arbiter bw_arbiter_chk #(.N(N_AGENTS)) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .grant(grant),
  .rel(rel), .urg(urg)
);

// File: tb/bw_arbiter_tb.sv
`timescale 1ns/1ps
module bw_arbiter_tb;

  localparam int N = 5;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         sel_we = 1'b0;
  logic [7:0]   sel_wdata = '0;
  logic         lim_we = 1'b0;
  logic         prd_we = 1'b0;
  logic         cmd_we = 1'b0;
  logic [7:0]   wdata = '0;
  logic [N-1:0] req = '0;
  logic         cmd_accept = 1'b0;
  logic [N-1:0] grant;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  string phase = "R1";

  always #2.5 clk = ~clk;

  bw_arbiter u_dut (
    .clk(clk), .rst_n(rst_n), .sel_we(sel_we), .sel_wdata(sel_wdata),
    .lim_we(lim_we), .prd_we(prd_we), .cmd_we(cmd_we), .wdata(wdata),
    .req(req), .cmd_accept(cmd_accept), .grant(grant)
  );

  // Behavioural reference model
  int lim_m[N], prd_m[N], cmd_m[N], wait_m[N];
  bit urg_m[N];
  int h_m, cnt_m, last_m, pres_m, sel_m;

  function automatic int pick(input bit c[N], input int last);
    for (int k = 1; k <= N; k++) begin
      int p = (last + k) % N;
      if (c[p]) return p;
    end
    return -1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        lim_m[i] = (i < 3) ? 31 : 4;
        cmd_m[i] = (i == 1 || i == 2) ? 16 : 4;
        prd_m[i] = 255;
        wait_m[i] = 0;
        urg_m[i] = 0;
      end
      h_m = -1; cnt_m = 0; last_m = N - 1; pres_m = 0; sel_m = 0;
    end else begin
      bit tick, rel, oth, any_u;
      bit el[N];
      bit cu[N];
      int cn, w;
      tick = (pres_m == 3);
      pres_m = (pres_m + 1) % 4;
      cn = cnt_m + (cmd_accept ? 1 : 0);
      oth = 0;
      for (int j = 0; j < N; j++) if (req[j] && j != h_m) oth = 1;
      rel = (h_m >= 0) && (!req[h_m] || (cn >= cmd_m[h_m] && oth) || cn >= lim_m[h_m]);
      any_u = 0;
      for (int j = 0; j < N; j++) begin
        el[j] = (h_m < 0 || rel) && req[j] && (j != h_m);
        if (el[j] && urg_m[j]) any_u = 1;
      end
      for (int j = 0; j < N; j++) cu[j] = any_u ? (el[j] && urg_m[j]) : el[j];
      // timers use the grant before this edge
      for (int j = 0; j < N; j++) begin
        if (!req[j] || j == h_m) begin
          wait_m[j] = 0; urg_m[j] = 0;
        end else if (tick && !urg_m[j]) begin
          if (wait_m[j] == prd_m[j]) urg_m[j] = 1;
          else wait_m[j]++;
        end
      end
      if (h_m < 0 || rel) begin
        w = pick(cu, last_m);
        cnt_m = 0;
        h_m = w;
        if (w >= 0) last_m = w;
      end else begin
        cnt_m = cn;
      end
      for (int j = 0; j < N; j++) begin
        if (lim_we && sel_m == j * 5) lim_m[j] = wdata & 8'h1f;
        if (prd_we && sel_m == j * 8) prd_m[j] = wdata;
        if (cmd_we && sel_m == j * 5) cmd_m[j] = wdata & 8'h1f;
      end
      if (sel_we) sel_m = sel_wdata;
    end
  end

  // Compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [N-1:0] exp;
      exp = (h_m < 0) ? '0 : (N'(1) << h_m);
      checks++;
      if (grant !== exp) begin
        errors++;
        $display("FAIL %s: grant actual %b expected %b at %0t", phase, grant, exp, $time);
      end
      checks++;
      if ($countones(grant) > 1) begin
        errors++;
        $display("FAIL R2: grant actual %b expected one-hot or zero", grant);
      end
    end
  end

  task automatic cfg_write(input int kind, input int selv, input int val);
    @(negedge clk);
    sel_we = 1'b1; sel_wdata = 8'(selv);
    @(negedge clk);
    sel_we = 1'b0;
    wdata = 8'(val);
    lim_we = (kind == 0); prd_we = (kind == 1); cmd_we = (kind == 2);
    @(negedge clk);
    lim_we = 1'b0; prd_we = 1'b0; cmd_we = 1'b0;
  endtask

  task automatic drive(input logic [N-1:0] r, input int every, input int cycles);
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      req = r;
      cmd_accept = (every > 0) && (c % every == 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (grant !== '0) begin
      errors++;
      $display("FAIL R1: reset grant actual %b expected 00000", grant);
    end
    rst_n = 1'b1;

    phase = "R1 R4";
    drive(5'b00011, 1, 40);

    phase = "R3";
    drive(5'b11111, 0, 40);

    phase = "R9";
    drive(5'b00000, 0, 4);
    cfg_write(0, 0, 2);     // agent0 lim = 2
    cfg_write(0, 3, 0);     // not a multiple of 5: ignored
    cfg_write(1, 40, 0);    // agent index 5 does not exist: ignored
    cfg_write(1, 32, 2);    // agent4 prd = 2
    cfg_write(2, 15, 1);    // agent3 cmd = 1
    cfg_write(1, 8, 0);     // agent1 prd = 0

    phase = "R6";
    drive(5'b00001, 1, 20);

    phase = "R8 R10";
    drive(5'b11110, 3, 200);

    phase = "R9 R4";
    drive(5'b01010, 1, 40);

    phase = "R5 R7";
    for (int s = 0; s < 3000; s++) begin
      @(negedge clk);
      if ($urandom_range(0, 3) == 0) req = N'($urandom);
      cmd_accept = $urandom_range(0, 1) == 1;
    end

    @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: actual still running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule